// File: doc/BRIEF.md
# Paired-Page Translation Lookup Buffer

This block is a fully associative translation buffer for 32-bit virtual addresses. Each of its entries covers one aligned pair of 4 KB virtual pages. The even page and the odd page each have their own frame number, valid bit and dirty bit. The tag of an entry is a virtual page-pair number, an 8-bit address-space identifier and a global bit. When the global bit is set, the identifier is not compared.

A lookup request carries a virtual address, a write flag and the current address-space identifier. It enters through a valid/ready handshake. The block resolves the lookup in one combinational pass, then registers the result. The result leaves on a valid/ready response channel together with a 2-bit result code, the physical address and the read and write permissions.

The request side accepts a new lookup only when the output register is empty, or when its current contents are being taken in the same cycle (`req_ready = !rsp_valid || rsp_ready`). While `rsp_valid` is high and `rsp_ready` is low, the response holds still and no new request is accepted. Entries are loaded through a plain write port addressed by entry index.

Top module: `tlb_pair_lookup`

## Requirements
- R1: An entry hits when its stored page-pair number equals address bits 31..13 and either its global bit is set or its stored identifier equals `req_asid`.
- R2: Address bit 12 picks the half of the pair: 0 uses the even frame, valid and dirty fields, and 1 uses the odd ones.
- R3: If the chosen half is not valid, the result code is 1 (invalid) even though the tag hit.
- R4: A read from a valid half gives code 0 (match). A write to a valid half gives code 0 only when that half's dirty bit is set; otherwise it gives code 2 (modified).
- R5: On code 0, `rsp_paddr` is the chosen frame number concatenated with address bits 11..0, `rsp_can_read` is 1 and `rsp_can_write` equals the dirty bit. On every other code, the address and both permissions are 0.
- R6: When no entry hits, the result code is 3 (no-match).
- R7: When several entries hit, the entry with the lowest index decides the result.
- R8: A request accepted on a clock edge has its response valid right after that edge. While the response is stalled, it holds stable and `req_ready` is low.
- R9: A write loads all fields of entry `wr_index` on the clock edge where `wr_en` is high. A lookup accepted on that same edge still sees the previous contents.
- R10: After reset, `rsp_valid` is 0, `req_ready` is 1 and every entry has all fields zero. A lookup of address 0 with identifier 0 therefore returns code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be accepted |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_asid | input | 8 | Current address-space identifier |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_code | output | 2 | 0 match, 1 invalid, 2 modified, 3 no-match |
| rsp_paddr | output | 32 | Physical address (0 unless match) |
| rsp_can_read | output | 1 | Read permitted |
| rsp_can_write | output | 1 | Write permitted |
| wr_en | input | 1 | Load an entry |
| wr_index | input | IDX_W | Entry index to load |
| wr_vpn2 | input | 19 | Page-pair number |
| wr_asid | input | 8 | Entry identifier |
| wr_global | input | 1 | Global bit |
| wr_pfn_even | input | 20 | Even-half frame number |
| wr_valid_even | input | 1 | Even-half valid |
| wr_dirty_even | input | 1 | Even-half dirty (writable) |
| wr_pfn_odd | input | 20 | Odd-half frame number |
| wr_valid_odd | input | 1 | Odd-half valid |
| wr_dirty_odd | input | 1 | Odd-half dirty (writable) |

## Verification
The bench builds the block with `NUM_ENTRIES = 8`, which gives `IDX_W = 3`. With that size, loading the highest index and filling the whole array take only a few cycles. Two entries that alias at indices 1 and 6 show the priority rule across most of the array. A sweep of lookups then covers every loaded entry, both halves, both access kinds and foreign identifiers. Each expected result comes from a shadow copy of the written entries.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W       = 32;
  localparam int PAGE_OFF_W = 12;
  localparam int ASID_W     = 8;
  localparam int PFN_W      = 20;
  localparam int VPN2_W     = VA_W - PAGE_OFF_W - 1;
  localparam int PA_W       = PFN_W + PAGE_OFF_W;

  typedef enum logic [1:0] {
    RES_MATCH    = 2'd0,
    RES_INVALID  = 2'd1,
    RES_MODIFIED = 2'd2,
    RES_NOMATCH  = 2'd3
  } tlb_res_e;

  typedef struct packed {
    logic [VPN2_W-1:0] vpn2;
    logic [ASID_W-1:0] asid;
    logic              glob;
    logic [PFN_W-1:0]  pfn_even;
    logic              v_even;
    logic              d_even;
    logic [PFN_W-1:0]  pfn_odd;
    logic              v_odd;
    logic              d_odd;
  } tlb_entry_t;
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_index,
  input  tlb_entry_t                   wr_entry,
  output tlb_entry_t [NUM_ENTRIES-1:0] entries_o
);

  // One register slot per entry; each slot decodes its own index.
  for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_slot
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(gi);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        entries_o[gi] <= '0;
      end else if (wr_en && (wr_index == MY_IDX)) begin
        entries_o[gi] <= wr_entry;
      end
    end
  end

  // R9: a write to an existing index is visible after the edge
  a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (32'(wr_index) < NUM_ENTRIES)) |=>
      (entries_o[$past(wr_index)] == $past(wr_entry)));

endmodule

// File: rtl/tlb_hit_select.sv
module tlb_hit_select
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  tlb_entry_t [NUM_ENTRIES-1:0] entries_i,
  input  logic [VPN2_W-1:0]            vpn2_i,
  input  logic [ASID_W-1:0]            asid_i,
  output logic                         hit_any_o,
  output tlb_entry_t                   sel_entry_o
);

  logic [NUM_ENTRIES-1:0] hit_vec;
  logic [NUM_ENTRIES-1:0] grant_vec;

  // Tag compare per entry: page-pair number, plus identifier unless global.
  for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_cmp
    assign hit_vec[gi] = (entries_i[gi].vpn2 == vpn2_i) &&
                         (entries_i[gi].glob || (entries_i[gi].asid == asid_i));
  end

  // Lowest index wins: isolate the lowest set bit.
  assign grant_vec = hit_vec & (~hit_vec + NUM_ENTRIES'(1));
  assign hit_any_o = |hit_vec;

  // AND-OR multiplexer driven by the one-hot grant.
  always_comb begin
    sel_entry_o = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      sel_entry_o = sel_entry_o | (grant_vec[i] ? entries_i[i] : '0);
    end
  end

  // R7: at most one entry selected
  a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

  // R7: any hit produces exactly one winner
  a_r7_hit_has_winner: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any_o |-> ($countones(grant_vec) == 1));

endmodule

// File: rtl/tlb_pair_resolve.sv
module tlb_pair_resolve
  import tlb_pkg::*;
(
  input  logic                  hit_any_i,
  input  tlb_entry_t            entry_i,
  input  logic [VA_W-1:0]       vaddr_i,
  input  logic                  write_i,
  output tlb_res_e              code_o,
  output logic [PA_W-1:0]       paddr_o,
  output logic                  can_read_o,
  output logic                  can_write_o
);

  localparam int HALF_BIT = PAGE_OFF_W;

  logic             odd_half;
  logic [PFN_W-1:0] half_pfn;
  logic             half_valid;
  logic             half_dirty;

  assign odd_half   = vaddr_i[HALF_BIT];
  assign half_pfn   = odd_half ? entry_i.pfn_odd : entry_i.pfn_even;
  assign half_valid = odd_half ? entry_i.v_odd   : entry_i.v_even;
  assign half_dirty = odd_half ? entry_i.d_odd   : entry_i.d_even;

  always_comb begin
    code_o      = RES_NOMATCH;
    paddr_o     = '0;
    can_read_o  = 1'b0;
    can_write_o = 1'b0;
    if (hit_any_i) begin
      if (!half_valid) begin
        code_o = RES_INVALID;
      end else if (write_i && !half_dirty) begin
        code_o = RES_MODIFIED;
      end else begin
        code_o      = RES_MATCH;
        paddr_o     = {half_pfn, vaddr_i[PAGE_OFF_W-1:0]};
        can_read_o  = 1'b1;
        can_write_o = half_dirty;
      end
    end
  end

endmodule

// File: rtl/tlb_pair_lookup.sv
module tlb_pair_lookup
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [31:0]           req_vaddr,
  input  logic                  req_write,
  input  logic [7:0]            req_asid,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [1:0]            rsp_code,
  output logic [31:0]           rsp_paddr,
  output logic                  rsp_can_read,
  output logic                  rsp_can_write,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_index,
  input  logic [18:0]           wr_vpn2,
  input  logic [7:0]            wr_asid,
  input  logic                  wr_global,
  input  logic [19:0]           wr_pfn_even,
  input  logic                  wr_valid_even,
  input  logic                  wr_dirty_even,
  input  logic [19:0]           wr_pfn_odd,
  input  logic                  wr_valid_odd,
  input  logic                  wr_dirty_odd
);

  localparam int VPN2_LSB = PAGE_OFF_W + 1;

  tlb_entry_t [NUM_ENTRIES-1:0] entries;
  tlb_entry_t                   wr_entry;
  tlb_entry_t                   sel_entry;
  logic                         hit_any;
  tlb_res_e                     res_code;
  logic [PA_W-1:0]              res_paddr;
  logic                         res_rd;
  logic                         res_wr;
  logic                         accept;

  assign wr_entry = '{vpn2: wr_vpn2, asid: wr_asid, glob: wr_global,
                      pfn_even: wr_pfn_even, v_even: wr_valid_even, d_even: wr_dirty_even,
                      pfn_odd: wr_pfn_odd, v_odd: wr_valid_odd, d_odd: wr_dirty_odd};

  tlb_entry_store #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_index  (wr_index),
    .wr_entry  (wr_entry),
    .entries_o (entries)
  );

  tlb_hit_select #(.NUM_ENTRIES(NUM_ENTRIES)) u_select (
    .clk         (clk),
    .rst_n       (rst_n),
    .entries_i   (entries),
    .vpn2_i      (req_vaddr[VA_W-1:VPN2_LSB]),
    .asid_i      (req_asid),
    .hit_any_o   (hit_any),
    .sel_entry_o (sel_entry)
  );

  tlb_pair_resolve u_resolve (
    .hit_any_i   (hit_any),
    .entry_i     (sel_entry),
    .vaddr_i     (req_vaddr),
    .write_i     (req_write),
    .code_o      (res_code),
    .paddr_o     (res_paddr),
    .can_read_o  (res_rd),
    .can_write_o (res_wr)
  );

  // Single output register; refills when empty or drained this cycle.
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_code      <= RES_NOMATCH;
      rsp_paddr     <= '0;
      rsp_can_read  <= 1'b0;
      rsp_can_write <= 1'b0;
    end else if (accept) begin
      rsp_valid     <= 1'b1;
      rsp_code      <= res_code;
      rsp_paddr     <= res_paddr;
      rsp_can_read  <= res_rd;
      rsp_can_write <= res_wr;
    end else if (rsp_ready) begin
      rsp_valid     <= 1'b0;
    end
  end

  // R8: accepted request yields a response after the edge
  a_r8_rsp_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R8: stalled response holds still
  a_r8_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_code) && $stable(rsp_paddr)
                                   && $stable(rsp_can_read) && $stable(rsp_can_write)));

  // R5: faults carry no address and no permission
  a_r5_fault_is_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_code != RES_MATCH)) |->
      (!rsp_can_read && !rsp_can_write && (rsp_paddr == '0)));

  // R4: a match always grants read
  a_r4_match_readable: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_code == RES_MATCH)) |-> rsp_can_read);

endmodule

// File: tb/tlb_pair_lookup_tb.sv
module tlb_pair_lookup_tb;
  localparam int N     = 8;
  localparam int IDX_W = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic [7:0]  req_asid = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_paddr;
  logic        rsp_can_read, rsp_can_write;
  logic        wr_en = 1'b0;
  logic [IDX_W-1:0] wr_index = '0;
  logic [18:0] wr_vpn2 = '0;
  logic [7:0]  wr_asid = '0;
  logic        wr_global = 1'b0;
  logic [19:0] wr_pfn_even = '0, wr_pfn_odd = '0;
  logic        wr_valid_even = 1'b0, wr_dirty_even = 1'b0;
  logic        wr_valid_odd = 1'b0, wr_dirty_odd = 1'b0;

  always #2 clk = ~clk;

  tlb_pair_lookup #(.NUM_ENTRIES(N), .IDX_W(IDX_W)) u_dut (.*);

  int tests = 0;
  int fails = 0;

  // Shadow of written entries (the bench's own model of the requirements)
  logic [18:0] m_vpn2 [N];
  logic [7:0]  m_asid [N];
  logic        m_g [N];
  logic [19:0] m_pe [N], m_po [N];
  logic        m_ve [N], m_de [N], m_vo [N], m_do [N];

  typedef struct {
    logic [1:0]  code;
    logic [31:0] pa;
    logic        rd;
    logic        wr;
  } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  function automatic exp_t model(input logic [31:0] va, input logic w, input logic [7:0] asid);
    exp_t e;
    int   hit;
    logic v, d;
    logic [19:0] pfn;
    e.code = 2'd3; e.pa = '0; e.rd = 1'b0; e.wr = 1'b0;
    hit = -1;
    for (int i = N - 1; i >= 0; i--)
      if (m_vpn2[i] == va[31:13] && (m_g[i] || m_asid[i] == asid)) hit = i;
    if (hit >= 0) begin
      v   = va[12] ? m_vo[hit] : m_ve[hit];
      d   = va[12] ? m_do[hit] : m_de[hit];
      pfn = va[12] ? m_po[hit] : m_pe[hit];
      if (!v) e.code = 2'd1;
      else if (w && !d) e.code = 2'd2;
      else begin
        e.code = 2'd0; e.pa = {pfn, va[11:0]}; e.rd = 1'b1; e.wr = d;
      end
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic drive_write(input int idx, input logic [18:0] vpn2, input logic [7:0] asid,
                             input logic g, input logic [19:0] pe, input logic ve, input logic de,
                             input logic [19:0] po, input logic vo, input logic dd);
    wr_en = 1'b1; wr_index = IDX_W'(idx); wr_vpn2 = vpn2; wr_asid = asid; wr_global = g;
    wr_pfn_even = pe; wr_valid_even = ve; wr_dirty_even = de;
    wr_pfn_odd = po; wr_valid_odd = vo; wr_dirty_odd = dd;
  endtask

  task automatic shadow_update(input int idx);
    m_vpn2[idx] = wr_vpn2; m_asid[idx] = wr_asid; m_g[idx] = wr_global;
    m_pe[idx] = wr_pfn_even; m_ve[idx] = wr_valid_even; m_de[idx] = wr_dirty_even;
    m_po[idx] = wr_pfn_odd; m_vo[idx] = wr_valid_odd; m_do[idx] = wr_dirty_odd;
  endtask

  task automatic load(input int idx, input logic [18:0] vpn2, input logic [7:0] asid,
                      input logic g, input logic [19:0] pe, input logic ve, input logic de,
                      input logic [19:0] po, input logic vo, input logic dd);
    @(posedge clk); #1;
    drive_write(idx, vpn2, asid, g, pe, ve, de, po, vo, dd);
    @(posedge clk); #1;
    wr_en = 1'b0;
    shadow_update(idx);
  endtask

  // Driver: issue one lookup, push its expected result at acceptance
  task automatic lookup(input logic [31:0] va, input logic w, input logic [7:0] asid,
                        input string tag);
    bit ok;
    @(posedge clk); #1;
    req_valid = 1'b1; req_vaddr = va; req_write = w; req_asid = asid;
    ok = 1'b0;
    while (!ok) begin
      @(negedge clk);
      ok = req_ready;
      if (ok) begin
        exp_q.push_back(model(va, w, asid));
        tag_q.push_back(tag);
      end
      @(posedge clk);
    end
    #1 req_valid = 1'b0;
    @(negedge clk);
    // R8: response present right after the accepting edge
    check(rsp_valid === 1'b1, "R8", "latency", 64'(rsp_valid), 64'd1);
  endtask

  // Monitor: compare every transferred response with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8", "unexpected response", 64'(rsp_code), 64'd0);
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rsp_code == e.code, t, "code", 64'(rsp_code), 64'(e.code));
        check(rsp_paddr == e.pa, t, "paddr", 64'(rsp_paddr), 64'(e.pa));
        check({rsp_can_read, rsp_can_write} == {e.rd, e.wr}, t, "perm",
              64'({rsp_can_read, rsp_can_write}), 64'({e.rd, e.wr}));
      end
    end
  end

  task automatic drain;
    while (exp_q.size() != 0) @(posedge clk);
    @(posedge clk);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R8 watchdog: actual hung expected done");
    finish_run();
  end

  initial begin : stim
    for (int i = 0; i < N; i++) begin
      m_vpn2[i] = '0; m_asid[i] = '0; m_g[i] = 1'b0;
      m_pe[i] = '0; m_po[i] = '0;
      m_ve[i] = 1'b0; m_de[i] = 1'b0; m_vo[i] = 1'b0; m_do[i] = 1'b0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state at the ports
    check(rsp_valid === 1'b0, "R10", "rsp_valid", 64'(rsp_valid), 64'd0);
    check(req_ready === 1'b1, "R10", "req_ready", 64'(req_ready), 64'd1);
    // R10: cleared entry 0 hits address 0 / id 0 with valid clear -> code 1
    lookup(32'h0000_0000, 1'b0, 8'd0, "R10");

    // Entry 2: even half writable, odd half read only
    load(2, 19'h12345, 8'd5, 1'b0, 20'hAAAAA, 1'b1, 1'b1, 20'h55555, 1'b1, 1'b0);
    lookup({19'h12345, 1'b0, 12'h123}, 1'b0, 8'd5, "R1");
    lookup({19'h12345, 1'b0, 12'hFFF}, 1'b1, 8'd5, "R5");
    lookup({19'h12345, 1'b1, 12'h0A5}, 1'b0, 8'd5, "R2");
    lookup({19'h12345, 1'b1, 12'h0A5}, 1'b1, 8'd5, "R4");
    lookup({19'h12345, 1'b0, 12'h123}, 1'b0, 8'd6, "R6");
    lookup({19'h12346, 1'b0, 12'h123}, 1'b0, 8'd5, "R6");

    // Entry 5: global, even half invalid, odd half writable
    load(5, 19'h00010, 8'd9, 1'b1, 20'h11111, 1'b0, 1'b1, 20'h22222, 1'b1, 1'b1);
    lookup({19'h00010, 1'b1, 12'h800}, 1'b1, 8'd3, "R1");
    lookup({19'h00010, 1'b0, 12'h800}, 1'b0, 8'd3, "R3");
    lookup({19'h00010, 1'b0, 12'h800}, 1'b1, 8'd9, "R3");

    // Aliased entries 6 and 1: the lower index decides
    load(6, 19'h07777, 8'd1, 1'b0, 20'hBBBBB, 1'b1, 1'b1, 20'hBBBBC, 1'b1, 1'b1);
    load(1, 19'h07777, 8'd1, 1'b0, 20'hCCCCC, 1'b1, 1'b0, 20'hCCCCD, 1'b0, 1'b0);
    lookup({19'h07777, 1'b0, 12'h010}, 1'b0, 8'd1, "R7");
    lookup({19'h07777, 1'b0, 12'h010}, 1'b1, 8'd1, "R7");
    lookup({19'h07777, 1'b1, 12'h010}, 1'b0, 8'd1, "R7");

    // Highest index
    load(N - 1, 19'h7FFFF, 8'hFF, 1'b0, 20'hFFFFE, 1'b1, 1'b1, 20'hFFFFF, 1'b1, 1'b0);
    lookup(32'hFFFF_FFFF, 1'b0, 8'hFF, "R2");
    lookup(32'hFFFF_EFFF, 1'b1, 8'hFF, "R5");

    // R9: write and lookup on the same edge; lookup sees old contents
    drain();
    @(posedge clk); #1;
    drive_write(3, 19'h04242, 8'd7, 1'b0, 20'h0DEAD, 1'b1, 1'b1, 20'h0BEEF, 1'b1, 1'b1);
    req_valid = 1'b1; req_vaddr = {19'h04242, 1'b0, 12'h004}; req_write = 1'b0; req_asid = 8'd7;
    @(negedge clk);
    check(req_ready === 1'b1, "R9", "req_ready", 64'(req_ready), 64'd1);
    exp_q.push_back(model(req_vaddr, 1'b0, 8'd7));
    tag_q.push_back("R9");
    @(posedge clk); #1;
    req_valid = 1'b0; wr_en = 1'b0;
    shadow_update(3);
    lookup({19'h04242, 1'b0, 12'h004}, 1'b0, 8'd7, "R9");
    lookup({19'h04242, 1'b1, 12'h004}, 1'b1, 8'd7, "R9");

    // R8: back-pressure holds the response and blocks new requests
    drain();
    @(posedge clk); #1 rsp_ready = 1'b0;
    fork
      begin
        lookup({19'h12345, 1'b0, 12'h321}, 1'b0, 8'd5, "R8");
        lookup({19'h00010, 1'b1, 12'h321}, 1'b0, 8'd0, "R8");
      end
      begin
        logic [1:0]  c0;
        logic [31:0] p0;
        repeat (4) @(negedge clk);
        c0 = rsp_code; p0 = rsp_paddr;
        check(req_ready === 1'b0, "R8", "req_ready stalled", 64'(req_ready), 64'd0);
        repeat (3) @(negedge clk);
        check(rsp_valid === 1'b1 && rsp_code == c0 && rsp_paddr == p0, "R8", "hold",
              64'(rsp_paddr), 64'(p0));
        @(posedge clk); #1 rsp_ready = 1'b1;
      end
    join
    drain();

    // Sweep across all entries, both halves, both access kinds
    for (int k = 0; k < 48; k++) begin
      logic [18:0] vp;
      logic [7:0]  id;
      case (k % 6)
        0: vp = 19'h12345;
        1: vp = 19'h00010;
        2: vp = 19'h07777;
        3: vp = 19'h7FFFF;
        4: vp = 19'h04242;
        default: vp = 19'h00000;
      endcase
      id = (k % 4 == 3) ? 8'd2 : ((k % 6 == 0) ? 8'd5 : (k % 6 == 2) ? 8'd1 :
           (k % 6 == 3) ? 8'hFF : (k % 6 == 4) ? 8'd7 : 8'd0);
      lookup({vp, 1'(k / 6), 12'(k * 37)}, 1'(k % 2), id, (k % 2) ? "R4" : "R2");
    end
    drain();
    check(exp_q.size() == 0, "R8", "scoreboard empty", 64'(exp_q.size()), 64'd0);
    finish_run();
  end
endmodule